// File: doc/BRIEF.md
# Predicated Execute Stage with Condition Flags

This block is the execute stage of a 32-bit datapath in which every instruction is predicated. Each instruction arrives with a 4-bit condition code. The block tests that code against a stored four-bit flag register holding negative, zero, carry and overflow. If the test fails, the instruction is squashed: the destination write-enable stays low and the flag register keeps its value. If the test passes, the arithmetic/logic unit produces a result. The flag register is rewritten only when the instruction sets its set-flags bit, or when the instruction is a compare.

The result and the write-enable are combinational. They follow the inputs presented in the same cycle. The flag register is updated on the rising clock edge that ends the cycle, and `flags_o` shows the registered value. A register file and an operand shifter sit around the block and are not part of it.

The control path is a single flag register with two transitions. In UPDATE, a passing instruction that asks for a flag change loads the newly computed flags. In HOLD, every other cycle keeps the current flags.

Top module: `cond_exec_unit`

## Requirements
- R1: `cond_i` selects one of sixteen predicates on the stored flags:
  - 0000 Z=1
  - 0001 Z=0
  - 0010 C=1
  - 0011 C=0
  - 0100 N=1
  - 0101 N=0
  - 0110 V=1
  - 0111 V=0
  - 1000 C=1 and Z=0
  - 1001 C=0 or Z=1
  - 1010 N==V
  - 1011 N!=V
  - 1100 Z=0 and N==V
  - 1101 Z=1 or N!=V
- R2: When `valid_i` is 0, or when the predicate is false, `wr_en_o` is 0 and `flags_o` is unchanged after the next edge.
- R3: When `set_flags_i` is 0 and the opcode is not compare, `flags_o` is unchanged after the edge.
- R4: When the flags are updated, N takes bit 31 of the result and Z is 1 exactly when the result is all zeros. `flags_o` is ordered {N,Z,C,V} from bit 3 down to bit 0.
- R5: For add (000), C is the unsigned carry out of bit 31 and V is signed overflow. Add-with-carry (001) also adds the stored C.
- R6: Subtract (010) and compare (011) compute `opa_i - opb_i`. C is 1 exactly when `opa_i >= opb_i` as unsigned values, and V is signed overflow of the subtraction.
- R7: Compare never raises `wr_en_o`. When its predicate passes, it updates all four flags regardless of `set_flags_i`.
- R8: Move (100) yields `opb_i`. AND (101), OR (110) and XOR (111) combine the two operands bitwise. With set-flags, these four operations update only N and Z and keep C and V.
- R9: While `rst_n` is low, `flags_o` is 0000.
- R10: A valid, passing, non-compare instruction raises `wr_en_o` in the same cycle, with `res_o` holding the operation's value.
- R11: Condition 1110 always passes. Condition 1111 never passes, so an instruction carrying it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present this cycle |
| cond_i | input | 4 | Condition code |
| op_i | input | 3 | ALU opcode |
| set_flags_i | input | 1 | Request flag update |
| opa_i | input | 32 | Left operand |
| opb_i | input | 32 | Right operand |
| res_o | output | 32 | ALU result |
| wr_en_o | output | 1 | Destination write-enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds the block with its default 32-bit data width, so the signed overflow boundaries at 0x7FFFFFFF and 0x80000000 can be driven directly.

Flag states are loaded through the block's own instructions. First a flag-setting add fixes C and V, then a flag-setting move fixes N and Z. This reaches all twelve flag states a real result can produce; N and Z can never both be 1. Every one of the sixteen conditions is then tested in each of those twelve states.

Arithmetic expectations come from wide signed and unsigned sums computed in the bench.

// File: rtl/cexu_pkg.sv
package cexu_pkg;

    typedef enum logic [3:0] {
        CC_EQ = 4'b0000, CC_NE = 4'b0001, CC_CS = 4'b0010, CC_CC = 4'b0011,
        CC_MI = 4'b0100, CC_PL = 4'b0101, CC_VS = 4'b0110, CC_VC = 4'b0111,
        CC_HI = 4'b1000, CC_LS = 4'b1001, CC_GE = 4'b1010, CC_LT = 4'b1011,
        CC_GT = 4'b1100, CC_LE = 4'b1101, CC_AL = 4'b1110, CC_NV = 4'b1111
    } cond_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000, OP_ADC = 3'b001, OP_SUB = 3'b010, OP_CMP = 3'b011,
        OP_MOV = 3'b100, OP_AND = 3'b101, OP_ORR = 3'b110, OP_EOR = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic {
        FR_HOLD   = 1'b0,
        FR_UPDATE = 1'b1
    } flag_step_e;

endpackage

// File: rtl/cexu_cond_eval.sv
module cexu_cond_eval
    import cexu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);
    logic sgn_ge;

    assign sgn_ge = (flags_i.n == flags_i.v);

    always_comb begin
        unique case (cond_e'(cond_i))
            CC_EQ: pass_o = flags_i.z;
            CC_NE: pass_o = !flags_i.z;
            CC_CS: pass_o = flags_i.c;
            CC_CC: pass_o = !flags_i.c;
            CC_MI: pass_o = flags_i.n;
            CC_PL: pass_o = !flags_i.n;
            CC_VS: pass_o = flags_i.v;
            CC_VC: pass_o = !flags_i.v;
            CC_HI: pass_o = flags_i.c && !flags_i.z;
            CC_LS: pass_o = !flags_i.c || flags_i.z;
            CC_GE: pass_o = sgn_ge;
            CC_LT: pass_o = !sgn_ge;
            CC_GT: pass_o = !flags_i.z && sgn_ge;
            CC_LE: pass_o = flags_i.z || !sgn_ge;
            CC_AL: pass_o = 1'b1;
            CC_NV: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cexu_alu.sv
module cexu_alu
    import cexu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [2:0]        op_i,
    input  flags_t            flags_i,
    output logic [DATA_W-1:0] res_o,
    output flags_t            flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic              ovf;
    logic              arith;

    always_comb begin
        b_eff = opb_i;
        cin   = 1'b0;
        arith = 1'b0;
        unique case (alu_op_e'(op_i))
            OP_ADD: arith = 1'b1;
            OP_ADC: begin
                arith = 1'b1;
                cin   = flags_i.c;
            end
            OP_SUB, OP_CMP: begin
                arith = 1'b1;
                b_eff = ~opb_i;
                cin   = 1'b1;
            end
            default: arith = 1'b0;
        endcase
    end

    assign sum = {1'b0, opa_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    assign ovf = (opa_i[MSB] == b_eff[MSB]) && (sum[MSB] != opa_i[MSB]);

    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_MOV:  res_o = opb_i;
            OP_AND:  res_o = opa_i & opb_i;
            OP_ORR:  res_o = opa_i | opb_i;
            OP_EOR:  res_o = opa_i ^ opb_i;
            default: res_o = sum[DATA_W-1:0];
        endcase
        flags_o.n = res_o[MSB];
        flags_o.z = (res_o == '0);
        flags_o.c = arith ? sum[DATA_W] : flags_i.c;
        flags_o.v = arith ? ovf : flags_i.v;
    end
endmodule

// File: rtl/cexu_flag_reg.sv
module cexu_flag_reg
    import cexu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd_i,
    input  flags_t next_i,
    output flags_t flags_o
);
    flag_step_e step;

    always_comb begin
        step = upd_i ? FR_UPDATE : FR_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            unique case (step)
                FR_UPDATE: flags_o <= next_i;
                FR_HOLD:   flags_o <= flags_o;
            endcase
        end
    end
endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cexu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        cond_i,
    input  logic [2:0]        op_i,
    input  logic              set_flags_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);
    flags_t flags_q;
    flags_t flags_nx;
    logic   pass;
    logic   is_cmp;
    logic   fire;

    cexu_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (flags_q),
        .pass_o  (pass)
    );

    cexu_alu #(.DATA_W(DATA_W)) u_alu (
        .opa_i   (opa_i),
        .opb_i   (opb_i),
        .op_i    (op_i),
        .flags_i (flags_q),
        .res_o   (res_o),
        .flags_o (flags_nx)
    );

    assign is_cmp  = (alu_op_e'(op_i) == OP_CMP);
    assign fire    = valid_i && pass;
    assign wr_en_o = fire && !is_cmp;

    cexu_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (fire && (set_flags_i || is_cmp)),
        .next_i  (flags_nx),
        .flags_o (flags_q)
    );

    assign flags_o = flags_q;
endmodule

// File: rtl/cond_exec_unit_chk.sv
module cond_exec_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        cond_i,
    input logic [2:0]        op_i,
    input logic              set_flags_i,
    input logic [DATA_W-1:0] res_o,
    input logic              wr_en_o,
    input logic [3:0]        flags_o
);
    localparam logic [2:0] CMP_OP = 3'b011;

    // R2: no write without a valid instruction
    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !wr_en_o);

    // R2: flags hold when no instruction
    a_r2_idle_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags_o));

    // R3: no flag request and not a compare keeps flags
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags_i && op_i != CMP_OP) |=> $stable(flags_o));

    // R7: compare never writes the destination
    a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == CMP_OP) |-> !wr_en_o);

    // R8: logical and move keep carry and overflow
    a_r8_keep_cv: assert property (@(posedge clk) disable iff (!rst_n)
        op_i[2] |=> flags_o[1:0] == $past(flags_o[1:0]));

    // R4: written and flag-setting result drives N
    a_r4_n_from_result: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && set_flags_i) |=> flags_o[3] == $past(res_o[DATA_W-1]));

    // R11: never-condition has no effect
    a_r11_nv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1111) |-> !wr_en_o);

    a_r11_nv_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == 4'b1111) |=> $stable(flags_o));
endmodule

bind cond_exec_unit cond_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .cond_i      (cond_i),
    .op_i        (op_i),
    .set_flags_i (set_flags_i),
    .res_o       (res_o),
    .wr_en_o     (wr_en_o),
    .flags_o     (flags_o)
);

// File: tb/cond_exec_unit_bench.sv
module cond_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  cond_i = 4'b1110;
    logic [2:0]  op_i = 3'b000;
    logic        set_flags_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [31:0] res_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [3:0] exp_f = 4'b0000;

    always #10 clk = ~clk;

    cond_exec_unit u_cond_exec_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
        .op_i(op_i), .set_flags_i(set_flags_i), .opa_i(opa_i), .opb_i(opb_i),
        .res_o(res_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] f);
        bit n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_op(input string tag, input logic v, input logic [3:0] cc,
                          input logic [2:0] op, input logic s,
                          input logic [31:0] a, input logic [31:0] b);
        logic signed [33:0] sa, sb, sr;
        logic [32:0] ur;
        logic [31:0] r;
        logic nc, nv;
        bit pass, arith;
        sa = $signed({{2{a[31]}}, a});
        sb = $signed({{2{b[31]}}, b});
        arith = 1'b1;
        nc = exp_f[1];
        nv = exp_f[0];
        sr = '0;
        ur = '0;
        case (op)
            3'd0: begin ur = {1'b0, a} + {1'b0, b}; sr = sa + sb; end
            3'd1: begin
                ur = {1'b0, a} + {1'b0, b} + {32'd0, exp_f[1]};
                sr = sa + sb + {33'd0, exp_f[1]};
            end
            3'd2, 3'd3: begin ur = {1'b0, a} - {1'b0, b}; sr = sa - sb; end
            default: arith = 1'b0;
        endcase
        case (op)
            3'd4: r = b;
            3'd5: r = a & b;
            3'd6: r = a | b;
            3'd7: r = a ^ b;
            default: r = ur[31:0];
        endcase
        if (arith) begin
            nc = (op == 3'd2 || op == 3'd3) ? (a >= b) : ur[32];
            nv = (sr != $signed({{2{r[31]}}, r}));
        end
        pass = v && cond_ok(cc, exp_f);
        @(negedge clk);
        valid_i = v; cond_i = cc; op_i = op; set_flags_i = s; opa_i = a; opb_i = b;
        #2;
        chk({tag, " wr_en"}, {31'd0, wr_en_o}, {31'd0, pass && op != 3'd3});
        if (pass && op != 3'd3) chk({tag, " R10 result"}, res_o, r);
        if (pass && (s || op == 3'd3)) exp_f = {r[31], r == 32'd0, nc, nv};
        @(posedge clk);
        #1;
        chk({tag, " flags"}, {28'd0, flags_o}, {28'd0, exp_f});
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset flags", {28'd0, flags_o}, 32'd0);
        chk("R2 idle wr_en", {31'd0, wr_en_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 exhaustive sweep over reachable flag states
        for (int nz = 0; nz < 3; nz++) begin
            for (int cv = 0; cv < 4; cv++) begin
                logic [31:0] la, lb, mb;
                case (cv)
                    0: begin la = 32'd1;        lb = 32'd1;        end
                    1: begin la = 32'h7FFFFFFF; lb = 32'd1;        end
                    2: begin la = 32'hFFFFFFFF; lb = 32'd1;        end
                    default: begin la = 32'h80000000; lb = 32'h80000000; end
                endcase
                mb = (nz == 0) ? 32'd1 : (nz == 1) ? 32'd0 : 32'h80000000;
                run_op("R5 load cv", 1'b1, 4'hE, 3'd0, 1'b1, la, lb);
                run_op("R8 load nz", 1'b1, 4'hE, 3'd4, 1'b1, 32'd0, mb);
                for (int cc = 0; cc < 16; cc++)
                    run_op("R1 R11 cond sweep", 1'b1, cc[3:0], 3'd4, 1'b0, 32'd0, 32'h5A5A0000);
            end
        end

        // R6 overflow and unsigned compare boundaries
        run_op("R6 sub ovf", 1'b1, 4'hE, 3'd2, 1'b1, 32'h80000000, 32'd1);
        run_op("R6 sub ovf neg", 1'b1, 4'hE, 3'd2, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF);
        run_op("R7 cmp 5,2", 1'b1, 4'hE, 3'd3, 1'b0, 32'd5, 32'd2);
        run_op("R7 cmp 2,5", 1'b1, 4'hE, 3'd3, 1'b0, 32'd2, 32'd5);
        run_op("R7 cmp equal", 1'b1, 4'hE, 3'd3, 1'b0, 32'h1234, 32'h1234);
        run_op("R5 add ovf", 1'b1, 4'hE, 3'd0, 1'b1, 32'h7FFFFFFF, 32'd1);
        run_op("R5 add carry", 1'b1, 4'hE, 3'd0, 1'b1, 32'hFFFFFFFF, 32'd2);
        run_op("R5 adc", 1'b1, 4'hE, 3'd1, 1'b1, 32'h10, 32'h20);
        run_op("R5 adc to ovf", 1'b1, 4'hE, 3'd0, 1'b1, 32'hFFFFFFFF, 32'd1);
        run_op("R5 adc cin", 1'b1, 4'hE, 3'd1, 1'b1, 32'h7FFFFFFF, 32'd0);
        // R3 no set-flags: flags hold
        run_op("R3 add no S", 1'b1, 4'hE, 3'd0, 1'b0, 32'd0, 32'd0);
        run_op("R3 sub no S", 1'b1, 4'hE, 3'd2, 1'b0, 32'd3, 32'd9);
        // R8 logical ops keep C and V
        run_op("R5 set cv", 1'b1, 4'hE, 3'd0, 1'b1, 32'h80000000, 32'h80000000);
        run_op("R8 and", 1'b1, 4'hE, 3'd5, 1'b1, 32'hF0F0F0F0, 32'h0FF00FF0);
        run_op("R8 orr", 1'b1, 4'hE, 3'd6, 1'b1, 32'h80000000, 32'h1);
        run_op("R8 eor zero", 1'b1, 4'hE, 3'd7, 1'b1, 32'hCAFE, 32'hCAFE);
        run_op("R4 mov neg", 1'b1, 4'hE, 3'd4, 1'b1, 32'd0, 32'hFFFFFFFF);
        // R2 squashed instructions
        run_op("R2 invalid cmp", 1'b0, 4'hE, 3'd3, 1'b1, 32'd1, 32'd9);
        run_op("R2 false cond", 1'b1, 4'h0, 3'd0, 1'b1, 32'd0, 32'd0);
        run_op("R11 nv cmp", 1'b1, 4'hF, 3'd3, 1'b1, 32'd0, 32'd0);
        run_op("R11 al mov", 1'b1, 4'hE, 3'd4, 1'b0, 32'd0, 32'h77);
        // R9 reset again clears flags
        @(negedge clk);
        valid_i = 1'b0;
        rst_n = 1'b0;
        #2;
        chk("R9 async reset", {28'd0, flags_o}, 32'd0);
        exp_f = 4'b0000;
        @(negedge clk);
        rst_n = 1'b1;
        run_op("R9 after reset", 1'b1, 4'h0, 3'd4, 1'b0, 32'd0, 32'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule